// File: doc/BRIEF.md
# Floating-point register type-tag controller

This block keeps a hidden type tag for every entry of a floating-point register file. The register file may hold binary floating-point data, hex-based compatible floating-point data, three flavours of decimal floating-point data, or a raw memory image that has not yet been interpreted. The block does not touch the data path. For each request it works out which action the data path has to take on the register, then updates the tag.

Requests arrive one per cycle. A request is a single-register load, a bulk raw load, a bulk store, an arithmetic issue with up to `NOPS` register operands, or an interrupt save or restore of a register's full internal image. Every request produces one registered response in the following cycle. The response carries an action code and a resulting tag for each operand slot. For a save, it also carries the upper field of the wide image, which holds the tag. Conversion is lazy. Raw images are interpreted only when an arithmetic operation first reads them, and operands of the wrong family are zeroed and retagged before use.

Top module: `fpt_tag_ctrl`

## Requirements
- R1: After reset every tag is untyped (code 0). While reset is held and while no request is made, `rsp_valid` is low.
- R2: Tag codes are 0 untyped, 1 binary, 2 hex-compatible, 3 decimal, 4 compatible decimal and 5 modified compatible decimal. A single-register load (kind 0) with type 1..5 sets the tag to that type and answers action 0 (idle) with the new tag in slot 0.
- R3: On an arithmetic issue (kind 3), an enabled operand whose tag equals the requested type gets action 1 (use) and keeps its tag.
- R4: An enabled operand whose tag is one decimal type (3..5) and whose requested type is a different decimal type gets action 2 (convert), and its tag becomes the requested type.
- R5: An enabled operand whose typed tag and requested type are different and not both decimal gets action 3 (zero), and its tag becomes the requested type.
- R6: An enabled operand holding an untyped tag gets action 4 (interpret memory image), and its tag becomes the requested type.
- R7: A bulk store (kind 2) answers action 5 (to external format) with the current tag if the tag is typed. If the tag is untyped it answers action 6 (raw move) with tag 0. The tag is left unchanged in both cases.
- R8: A bulk raw load (kind 1) answers action 6 and sets the tag to 0.
- R9: A save (kind 4) answers action 6 with the current tag and leaves the tag unchanged. `sav_img_hi` carries the tag in bits [2:0] and zeros above. On every other response `sav_img_hi` is zero.
- R10: A restore (kind 5) answers action 6 and sets the tag from bits [2:0] of `rst_img_hi`. A field value of 6 or 7 restores as untyped (0).
- R11: A load or arithmetic issue whose requested type is 0, 6 or 7 answers action 0 and leaves the tag unchanged. The affected slot reports the current tag. Request kinds 6 and 7 answer action 0 with tag 0 in all slots.
- R12: Disabled operand slots, and slots above slot 0 for non-arithmetic kinds, report action 0 with tag 0. Operands naming the same register are each decided against the tag that held before the request.
- R13: Each accepted request gives exactly one response in the following cycle, with `rsp_kind` equal to the request kind. A following request sees the updated tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 load, 1 bulk raw load, 2 bulk store, 3 arithmetic, 4 save, 5 restore |
| req_type | input | 3 | Requested type code |
| req_en | input | NOPS | Operand enables (arithmetic only) |
| req_idx | input | NOPS*IDX_W | Register index per slot; slot 0 is used by the single-register kinds |
| rst_img_hi | input | IMG_W-PAY_W | Upper field of an image being restored |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 3 | Kind of the request answered |
| rsp_act | output | NOPS*3 | Action code per slot |
| rsp_tag | output | NOPS*3 | Resulting tag per slot |
| sav_img_hi | output | IMG_W-PAY_W | Upper image field for a save |

## Verification
The hardest situation to reach is a register passing through every transition in turn. It has to go from untyped, to interpreted, to converted within the decimal family, to zeroed into another family, back to untyped through a raw load, and then be saved and restored. Only a chained history of requests against the same index can produce that sequence. The stimulus therefore first walks directed chains on a few registers. It checks both operands aimed at one register, and corrupt restore fields. It then runs a long random mix confined to a small set of indices so that tags collide often. A bench-side tag model predicts every response.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
   localparam int TAG_W = 3;
   localparam int ACT_W = 3;

   localparam logic [TAG_W-1:0] T_RAW  = 3'd0;
   localparam logic [TAG_W-1:0] T_BIN  = 3'd1;
   localparam logic [TAG_W-1:0] T_HEX  = 3'd2;
   localparam logic [TAG_W-1:0] T_DEC  = 3'd3;
   localparam logic [TAG_W-1:0] T_CDEC = 3'd4;
   localparam logic [TAG_W-1:0] T_MDEC = 3'd5;

   localparam logic [ACT_W-1:0] A_IDLE = 3'd0;
   localparam logic [ACT_W-1:0] A_USE  = 3'd1;
   localparam logic [ACT_W-1:0] A_CONV = 3'd2;
   localparam logic [ACT_W-1:0] A_ZERO = 3'd3;
   localparam logic [ACT_W-1:0] A_IMG  = 3'd4;
   localparam logic [ACT_W-1:0] A_EXT  = 3'd5;
   localparam logic [ACT_W-1:0] A_MOVE = 3'd6;

   localparam logic [2:0] K_LOAD = 3'd0;
   localparam logic [2:0] K_BULK = 3'd1;
   localparam logic [2:0] K_STOR = 3'd2;
   localparam logic [2:0] K_ARITH = 3'd3;
   localparam logic [2:0] K_SAVE = 3'd4;
   localparam logic [2:0] K_REST = 3'd5;

   function automatic logic is_typed(input logic [TAG_W-1:0] t);
      return (t >= T_BIN) && (t <= T_MDEC);
   endfunction

   function automatic logic is_decimal(input logic [TAG_W-1:0] t);
      return (t >= T_DEC) && (t <= T_MDEC);
   endfunction
endpackage

// File: rtl/fpt_decide.sv
module fpt_decide
   import fpt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [TAG_W-1:0] cur_tag,
   input  logic [TAG_W-1:0] want,
   output logic [ACT_W-1:0] act,
   output logic [TAG_W-1:0] new_tag,
   output logic             wr
);
   always_comb begin
      act     = A_IDLE;
      new_tag = cur_tag;
      wr      = 1'b0;
      if (en && is_typed(want)) begin
         if (cur_tag == T_RAW) begin
            act = A_IMG;  new_tag = want; wr = 1'b1;
         end else if (cur_tag == want) begin
            act = A_USE;
         end else if (is_decimal(cur_tag) && is_decimal(want)) begin
            act = A_CONV; new_tag = want; wr = 1'b1;
         end else begin
            act = A_ZERO; new_tag = want; wr = 1'b1;
         end
      end
   end

   AST_USE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (act == A_USE) |-> (!wr && new_tag == cur_tag)); // R3
   AST_CONV_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (act == A_CONV) |-> (is_decimal(new_tag) && is_decimal(cur_tag) && wr)); // R4
   AST_ZERO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      (act == A_ZERO) |-> (cur_tag != T_RAW && !(is_decimal(cur_tag) && is_decimal(want)))); // R5
   AST_IMG_FROM_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (act == A_IMG) |-> (cur_tag == T_RAW && new_tag != T_RAW)); // R6
endmodule

// File: rtl/fpt_img_field.sv
module fpt_img_field
   import fpt_pkg::*;
#(
   parameter int HI_W = 32
) (
   input  logic [TAG_W-1:0] save_tag,
   input  logic [HI_W-1:0]  rest_hi,
   output logic [HI_W-1:0]  save_hi,
   output logic [TAG_W-1:0] rest_tag
);
   initial begin
      assert (HI_W >= TAG_W) else $error("image upper field too narrow for tag");
   end

   generate
      if (HI_W > TAG_W) begin : g_pad
         assign save_hi = {{(HI_W-TAG_W){1'b0}}, save_tag};
      end else begin : g_exact
         assign save_hi = save_tag;
      end
   endgenerate

   always_comb begin
      rest_tag = rest_hi[TAG_W-1:0];
      if (!is_typed(rest_tag)) rest_tag = T_RAW;
   end
endmodule

// File: rtl/fpt_tag_file.sv
module fpt_tag_file
   import fpt_pkg::*;
#(
   parameter int NREGS = 16,
   parameter int NWP   = 3,
   parameter int NRP   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NWP-1:0]       wr_en,
   input  logic [NWP*$clog2(NREGS)-1:0] wr_idx,
   input  logic [NWP*TAG_W-1:0] wr_tag,
   input  logic [NRP*$clog2(NREGS)-1:0] rd_idx,
   output logic [NRP*TAG_W-1:0] rd_tag
);
   localparam int IDX_W = $clog2(NREGS);

   initial begin
      assert (NREGS >= 2 && NREGS == (1 << IDX_W)) else $error("NREGS must be a power of two");
   end

   logic [TAG_W-1:0] tags [NREGS];

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tags[r] <= T_RAW;
         end else begin
            for (int w = 0; w < NWP; w++) begin
               if (wr_en[w] && wr_idx[w*IDX_W +: IDX_W] == IDX_W'(r))
                  tags[r] <= wr_tag[w*TAG_W +: TAG_W];
            end
         end
      end
      AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         tags[r] <= T_MDEC); // R2
   end

   for (genvar p = 0; p < NRP; p++) begin : g_rd
      assign rd_tag[p*TAG_W +: TAG_W] = tags[rd_idx[p*IDX_W +: IDX_W]];
   end
endmodule

// File: rtl/fpt_tag_ctrl.sv
module fpt_tag_ctrl
   import fpt_pkg::*;
#(
   parameter int NREGS = 16,
   parameter int NOPS  = 2,
   parameter int PAY_W = 128,
   parameter int IMG_W = 160
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [2:0]                    req_kind,
   input  logic [TAG_W-1:0]              req_type,
   input  logic [NOPS-1:0]               req_en,
   input  logic [NOPS*$clog2(NREGS)-1:0] req_idx,
   input  logic [IMG_W-PAY_W-1:0]        rst_img_hi,
   output logic                          rsp_valid,
   output logic [2:0]                    rsp_kind,
   output logic [NOPS*ACT_W-1:0]         rsp_act,
   output logic [NOPS*TAG_W-1:0]         rsp_tag,
   output logic [IMG_W-PAY_W-1:0]        sav_img_hi
);
   localparam int IDX_W = $clog2(NREGS);
   localparam int HI_W  = IMG_W - PAY_W;
   localparam int NWP   = NOPS + 1;

   initial begin
      assert (NOPS >= 1) else $error("need at least one operand slot");
      assert (IMG_W > PAY_W) else $error("image must exceed payload");
   end

   logic [NOPS*TAG_W-1:0] cur_f;
   logic [NOPS*ACT_W-1:0] d_act_f;
   logic [NOPS*TAG_W-1:0] d_tag_f;
   logic [NOPS-1:0]       d_wr;
   logic                  sw_en;
   logic [TAG_W-1:0]      sw_tag;
   logic [HI_W-1:0]       save_hi;
   logic [TAG_W-1:0]      rest_tag;
   logic [TAG_W-1:0]      cur0;

   assign cur0 = cur_f[TAG_W-1:0];

   for (genvar o = 0; o < NOPS; o++) begin : g_op
      fpt_decide u_dec (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (req_valid && req_kind == K_ARITH && req_en[o]),
         .cur_tag (cur_f[o*TAG_W +: TAG_W]),
         .want    (req_type),
         .act     (d_act_f[o*ACT_W +: ACT_W]),
         .new_tag (d_tag_f[o*TAG_W +: TAG_W]),
         .wr      (d_wr[o])
      );
   end

   fpt_img_field #(.HI_W(HI_W)) u_img (
      .save_tag (cur0),
      .rest_hi  (rst_img_hi),
      .save_hi  (save_hi),
      .rest_tag (rest_tag)
   );

   fpt_tag_file #(.NREGS(NREGS), .NWP(NWP), .NRP(NOPS)) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  ({sw_en, d_wr}),
      .wr_idx ({req_idx[IDX_W-1:0], req_idx}),
      .wr_tag ({sw_tag, d_tag_f}),
      .rd_idx (req_idx),
      .rd_tag (cur_f)
   );

   logic [NOPS*ACT_W-1:0] act_n;
   logic [NOPS*TAG_W-1:0] tag_n;
   logic [HI_W-1:0]       hi_n;

   always_comb begin
      act_n  = '0;
      tag_n  = '0;
      hi_n   = '0;
      sw_en  = 1'b0;
      sw_tag = T_RAW;
      if (req_valid) begin
         case (req_kind)
            K_ARITH: begin
               for (int o = 0; o < NOPS; o++) begin
                  if (req_en[o]) begin
                     act_n[o*ACT_W +: ACT_W] = d_act_f[o*ACT_W +: ACT_W];
                     tag_n[o*TAG_W +: TAG_W] = d_tag_f[o*TAG_W +: TAG_W];
                  end
               end
            end
            K_LOAD: begin
               if (is_typed(req_type)) begin
                  sw_en  = 1'b1;
                  sw_tag = req_type;
                  tag_n[TAG_W-1:0] = req_type;
               end else begin
                  tag_n[TAG_W-1:0] = cur0;
               end
            end
            K_BULK: begin
               sw_en = 1'b1;
               sw_tag = T_RAW;
               act_n[ACT_W-1:0] = A_MOVE;
            end
            K_STOR: begin
               act_n[ACT_W-1:0] = (cur0 == T_RAW) ? A_MOVE : A_EXT;
               tag_n[TAG_W-1:0] = cur0;
            end
            K_SAVE: begin
               act_n[ACT_W-1:0] = A_MOVE;
               tag_n[TAG_W-1:0] = cur0;
               hi_n = save_hi;
            end
            K_REST: begin
               sw_en  = 1'b1;
               sw_tag = rest_tag;
               act_n[ACT_W-1:0] = A_MOVE;
               tag_n[TAG_W-1:0] = rest_tag;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_kind   <= '0;
         rsp_act    <= '0;
         rsp_tag    <= '0;
         sav_img_hi <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_kind   <= req_kind;
         rsp_act    <= act_n;
         rsp_tag    <= tag_n;
         sav_img_hi <= hi_n;
      end
   end

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R13
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R1
   AST_BULK_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == K_BULK) |=> (rsp_tag[TAG_W-1:0] == T_RAW && rsp_act[ACT_W-1:0] == A_MOVE)); // R8
   AST_HI_ONLY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_kind == K_SAVE) |=> (sav_img_hi == '0)); // R9
endmodule

// File: tb/sim_fpt_tag_ctrl.sv
module sim_fpt_tag_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NREGS = 16;
   localparam int NOPS  = 2;
   localparam int IDX_W = 4;
   localparam int HI_W  = 32;

   typedef struct packed {
      logic [2:0]  kind;
      logic [5:0]  act;
      logic [5:0]  tag;
      logic [31:0] hi;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [2:0] req_kind = '0;
   logic [2:0] req_type = '0;
   logic [NOPS-1:0] req_en = '0;
   logic [NOPS*IDX_W-1:0] req_idx = '0;
   logic [HI_W-1:0] rst_img_hi = '0;
   logic rsp_valid;
   logic [2:0] rsp_kind;
   logic [5:0] rsp_act;
   logic [5:0] rsp_tag;
   logic [HI_W-1:0] sav_img_hi;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpt_tag_ctrl #(.NREGS(NREGS), .NOPS(NOPS), .PAY_W(128), .IMG_W(160)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_type(req_type), .req_en(req_en), .req_idx(req_idx), .rst_img_hi(rst_img_hi),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_act(rsp_act), .rsp_tag(rsp_tag),
      .sav_img_hi(sav_img_hi));

   int n_cmp = 0;
   int n_bad = 0;
   exp_t  q_exp[$];
   string q_req[$];
   logic [2:0] model [NREGS];

   function automatic logic typed(input logic [2:0] t);
      return t >= 3'd1 && t <= 3'd5;
   endfunction

   function automatic void decide(input logic [2:0] cur, input logic [2:0] rq,
                                  output logic [2:0] a, output logic [2:0] t);
      if (!typed(rq))                   begin a = 3'd0; t = cur; end
      else if (cur == 3'd0)             begin a = 3'd4; t = rq;  end
      else if (cur == rq)               begin a = 3'd1; t = cur; end
      else if (cur >= 3'd3 && rq >= 3'd3) begin a = 3'd2; t = rq; end
      else                              begin a = 3'd3; t = rq;  end
   endfunction

   task automatic send(input logic [2:0] kind, input logic [2:0] typ, input logic [1:0] en,
                       input int i0, input int i1, input logic [31:0] hi, input string rq);
      exp_t e;
      logic [2:0] c0, c1, a, t;
      e = '0;
      e.kind = kind;
      c0 = model[i0];
      c1 = model[i1];
      case (kind)
         3'd3: begin
            if (en[0]) begin decide(c0, typ, a, t); e.act[2:0] = a; e.tag[2:0] = t; end
            if (en[1]) begin decide(c1, typ, a, t); e.act[5:3] = a; e.tag[5:3] = t; end
            if (en[0]) model[i0] = e.tag[2:0];
            if (en[1]) model[i1] = e.tag[5:3];
         end
         3'd0: begin
            if (typed(typ)) begin model[i0] = typ; e.tag[2:0] = typ; end
            else e.tag[2:0] = c0;
         end
         3'd1: begin e.act[2:0] = 3'd6; model[i0] = 3'd0; end
         3'd2: begin e.act[2:0] = (c0 == 3'd0) ? 3'd6 : 3'd5; e.tag[2:0] = c0; end
         3'd4: begin e.act[2:0] = 3'd6; e.tag[2:0] = c0; e.hi = {29'd0, c0}; end
         3'd5: begin
            e.act[2:0] = 3'd6;
            e.tag[2:0] = typed(hi[2:0]) ? hi[2:0] : 3'd0;
            model[i0] = e.tag[2:0];
         end
         default: ;
      endcase
      q_exp.push_back(e);
      q_req.push_back(rq);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_type = typ; req_en = en;
      req_idx = {IDX_W'(i1), IDX_W'(i0)}; rst_img_hi = hi;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops one expected item per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_cmp++;
         if (q_exp.size() == 0) begin
            n_bad++;
            $display("FAIL R13: unexpected response act=%h tag=%h expected none", rsp_act, rsp_tag);
         end else begin
            exp_t e;
            string r;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            if (rsp_kind !== e.kind || rsp_act !== e.act || rsp_tag !== e.tag || sav_img_hi !== e.hi) begin
               n_bad++;
               $display("FAIL %s: kind/act/tag/hi actual %0d/%h/%h/%h expected %0d/%h/%h/%h",
                        r, rsp_kind, rsp_act, rsp_tag, sav_img_hi, e.kind, e.act, e.tag, e.hi);
            end
         end
      end
   end

   initial begin : wdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R13: watchdog expired, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int r = 0; r < NREGS; r++) model[r] = 3'd0;
      repeat (3) @(negedge clk);
      n_cmp++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: rsp_valid in reset actual %b expected 0", rsp_valid);
      end
      rst_n = 1'b1;
      // R1: every register untyped after reset (seen through bulk store)
      for (int r = 0; r < NREGS; r++) send(3'd2, 3'd0, 2'b00, r, 0, 32'd0, "R1");
      idle(2);
      n_cmp++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: rsp_valid idle actual %b expected 0", rsp_valid);
      end
      // R6: interpret raw images on first use
      send(3'd3, 3'd3, 2'b11, 2, 3, 32'd0, "R6");
      // R2 then R3 with both operands on one register (R12)
      send(3'd0, 3'd1, 2'b00, 4, 0, 32'd0, "R2");
      send(3'd3, 3'd1, 2'b11, 4, 4, 32'd0, "R12");
      send(3'd3, 3'd3, 2'b01, 2, 0, 32'd0, "R3");
      // R4: decimal family conversions
      send(3'd3, 3'd4, 2'b11, 2, 3, 32'd0, "R4");
      send(3'd3, 3'd5, 2'b01, 2, 0, 32'd0, "R4");
      send(3'd3, 3'd3, 2'b10, 0, 3, 32'd0, "R4");
      // R5: cross-family zeroing
      send(3'd3, 3'd2, 2'b01, 4, 0, 32'd0, "R5");
      send(3'd3, 3'd1, 2'b01, 2, 0, 32'd0, "R5");
      send(3'd3, 3'd3, 2'b01, 4, 0, 32'd0, "R5");
      send(3'd3, 3'd2, 2'b11, 3, 2, 32'd0, "R5");
      // R7: stores
      send(3'd2, 3'd0, 2'b00, 4, 0, 32'd0, "R7");
      send(3'd2, 3'd0, 2'b00, 5, 0, 32'd0, "R7");
      // R8: raw load then lazy interpretation
      send(3'd1, 3'd0, 2'b00, 4, 0, 32'd0, "R8");
      send(3'd2, 3'd0, 2'b00, 4, 0, 32'd0, "R8");
      send(3'd3, 3'd2, 2'b01, 4, 0, 32'd0, "R6");
      // R9: save
      send(3'd4, 3'd0, 2'b00, 4, 0, 32'd0, "R9");
      send(3'd4, 3'd0, 2'b00, 9, 0, 32'd0, "R9");
      // R10: restore, legal and corrupt fields
      send(3'd5, 3'd0, 2'b00, 6, 0, 32'hABCD_0004, "R10");
      send(3'd2, 3'd0, 2'b00, 6, 0, 32'd0, "R10");
      send(3'd5, 3'd0, 2'b00, 7, 0, 32'h0000_0007, "R10");
      send(3'd2, 3'd0, 2'b00, 7, 0, 32'd0, "R10");
      // R11: illegal types and kinds
      send(3'd3, 3'd0, 2'b01, 6, 0, 32'd0, "R11");
      send(3'd0, 3'd6, 2'b00, 6, 0, 32'd0, "R11");
      send(3'd2, 3'd0, 2'b00, 6, 0, 32'd0, "R11");
      send(3'd7, 3'd3, 2'b11, 6, 6, 32'd0, "R11");
      send(3'd6, 3'd1, 2'b11, 1, 1, 32'd0, "R11");
      // R12: disabled slot
      send(3'd3, 3'd4, 2'b01, 6, 6, 32'd0, "R12");
      send(3'd3, 3'd4, 2'b00, 6, 6, 32'd0, "R12");
      // R13: random back-to-back mix on few registers
      for (int n = 0; n < 600; n++) begin
         logic [2:0] k;
         k = 3'($urandom_range(0, 7));
         if (k > 3'd5 && ($urandom_range(0, 3) != 0)) k = 3'd3;
         send(k, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
              $urandom_range(0, 3), $urandom_range(0, 3), $urandom, "R13");
      end
      idle(4);
      n_cmp++;
      if (q_exp.size() != 0) begin
         n_bad++;
         $display("FAIL R13: pending responses actual %0d expected 0", q_exp.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule